// File: doc/BRIEF.md
# Descriptor Ring Ownership Walker

This block serves one channel of a descriptor-based DMA engine. It walks a circular ring of 8-byte descriptors in memory. Each descriptor holds a 32-bit control word followed by a 32-bit buffer address. A single bit in the control word decides who owns the descriptor. Software sets that bit to hand the descriptor to hardware, and the walker clears it when it hands the descriptor back.

The walker has no doorbell. A free-running poll timer starts each scan. When a tick finds the current descriptor owned by hardware, the walker reads the buffer address and passes a transfer request to a data mover. When the mover reports completion, the walker writes the control word back with ownership returned and the complete flag set. It then pulses a completion event, advances the index and checks the next descriptor at once. A descriptor that software still owns stops the walk until a later tick finds it owned.

Top module: `dring_walker`

## Requirements
- R1: After reset the walker makes no memory request and no transfer request, `desc_done` is low and `cur_idx` is 0.
- R2: While the walker is idle, a descriptor fetch starts only on a poll tick. With polling disabled the walker makes no memory request.
- R3: Poll ticks are `POLL_CYC` cycles apart, or 4·`POLL_CYC` cycles apart when `cfg_poll_div4` is 1. A ctl read on an unowned descriptor therefore repeats at exactly that spacing.
- R4: Descriptor `i` is read at `cfg_base + 8*i`, control word first, and its buffer address at `cfg_base + 8*i + 4`.
- R5: If control bit 31 (owner) reads 1, the walker fetches the address word and requests a transfer. If it reads 0, the walker writes nothing, requests no transfer and waits for the next tick.
- R6: The transfer takes its length from control bits 15:0, start of packet from bit 29, end of packet from bit 28, and its address from the second descriptor word.
- R7: The byte offset comes from control bits 27:23 on a transmit channel (`cfg_is_tx`=1). On a receive channel it comes from bits 25:23, zero-extended to 5 bits.
- R8: After completion the walker makes one write to the control word address. That write has bit 31 at 0, bit 30 (complete) at 1, bits 15:0 equal to `xfer_count`, and all other bits as read. It is followed by a one-cycle `desc_done` pulse.
- R9: After a completion the index advances and the next control word is read in the same cycle that `desc_done` is high, without waiting for a tick.
- R10: The index wraps from `cfg_len-1` to 0.
- R11: A `ch_rst` pulse returns the index to 0 and abandons any fetch in progress. A read response that arrives late is ignored, and the descriptor being fetched is neither transferred nor written.
- R12: Only one memory request and one transfer are outstanding at a time. A request holds its address and data until it is granted, and a transfer request holds its fields until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| ch_rst | input | 1 | Synchronous channel reset |
| cfg_base | input | ADDR_W | Ring base byte address |
| cfg_len | input | IDX_W | Ring length in descriptors |
| cfg_is_tx | input | 1 | 1 selects transmit offset width, 0 receive |
| cfg_poll_en | input | 1 | Enables the poll timer |
| cfg_poll_div4 | input | 1 | Makes the poll period four times longer |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 16 | Byte count |
| xfer_ofs | output | 5 | Byte offset |
| xfer_sop | output | 1 | Start of packet |
| xfer_eop | output | 1 | End of packet |
| xfer_done | input | 1 | Transfer finished |
| xfer_count | input | 16 | Bytes actually moved |
| desc_done | output | 1 | Descriptor completion event |
| cur_idx | output | IDX_W | Current ring index |

## Verification
The embedded assertions check properties that hold on every cycle: request and transfer stability while waiting for a grant or completion, the flags of every write-back, the single-cycle completion pulse, the immediate next fetch after a completion, the stop on an unowned descriptor, the quiet cycle after a channel reset, and the index stepping by one or wrapping. The bench scenarios cover what needs memory contents or long time spans. Those are the field extraction for both offset widths, the exact write-back word, the wrap into a re-armed entry, a reset arriving while a slow read is pending, and the measured poll spacing with and without the divider.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;

  // Control word layout (hardware and software agree on these positions)
  localparam int unsigned OWN_B     = 31;
  localparam int unsigned CMPL_B    = 30;
  localparam int unsigned SOP_B     = 29;
  localparam int unsigned EOP_B     = 28;
  localparam int unsigned OFS_LSB   = 23;
  localparam int unsigned TX_OFS_W  = 5;
  localparam int unsigned RX_OFS_W  = 3;
  localparam int unsigned CNT_W     = 16;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned DESC_SHIFT = 3;

  typedef enum logic [2:0] {
    W_IDLE = 3'd0,
    W_RCTL = 3'd1,
    W_WCTL = 3'd2,
    W_RADR = 3'd3,
    W_WADR = 3'd4,
    W_XFER = 3'd5,
    W_WB   = 3'd6
  } walk_state_e;

endpackage

// File: rtl/dwalk_poll_timer.sv
module dwalk_poll_timer #(
  parameter int unsigned POLL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic div4,
  output logic tick
);

  localparam int unsigned LONG_CYC = POLL_CYC * 4;
  localparam int unsigned TW       = $clog2(LONG_CYC + 1);

  logic [TW-1:0] cnt_q, cnt_d, limit;

  initial begin
    if (POLL_CYC < 2) $error("POLL_CYC must be at least 2");
  end

  always_comb begin
    limit = div4 ? TW'(LONG_CYC - 1) : TW'(POLL_CYC - 1);
    tick  = en && !clr && (cnt_q >= limit);
    if (clr || !en || tick) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R3

  AST_NO_TICK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);  // R2

endmodule

// File: rtl/dwalk_ring_idx.sv
module dwalk_ring_idx #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [IDX_W-1:0] len,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_last;

  always_comb begin
    at_last = (idx_q >= (len - 1'b1));
    idx_d   = idx_q;
    if (clr)          idx_d = '0;
    else if (adv)     idx_d = at_last ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (idx_q == '0) || (idx_q == $past(idx_q) + 1'b1));  // R10

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(idx_q));  // R10

endmodule

// File: rtl/dwalk_ctl_fmt.sv
module dwalk_ctl_fmt
  import dwalk_pkg::*;
(
  input  logic [WORD_W-1:0]   ctl,
  input  logic                is_tx,
  input  logic [CNT_W-1:0]    moved,
  output logic                own,
  output logic                sop,
  output logic                eop,
  output logic [CNT_W-1:0]    len,
  output logic [TX_OFS_W-1:0] ofs,
  output logic [WORD_W-1:0]   wb_word
);

  logic [TX_OFS_W-1:0] ofs_tx, ofs_rx;

  always_comb begin
    own    = ctl[OWN_B];
    sop    = ctl[SOP_B];
    eop    = ctl[EOP_B];
    len    = ctl[CNT_W-1:0];
    ofs_tx = ctl[OFS_LSB +: TX_OFS_W];
    ofs_rx = TX_OFS_W'(ctl[OFS_LSB +: RX_OFS_W]);
    ofs    = is_tx ? ofs_tx : ofs_rx;

    wb_word              = ctl;
    wb_word[OWN_B]       = 1'b0;
    wb_word[CMPL_B]      = 1'b1;
    wb_word[CNT_W-1:0]   = moved;
  end

endmodule

// File: rtl/dring_walker.sv
module dring_walker
  import dwalk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned POLL_CYC = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch_rst,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [IDX_W-1:0]    cfg_len,
  input  logic                cfg_is_tx,
  input  logic                cfg_poll_en,
  input  logic                cfg_poll_div4,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic                mem_gnt,
  input  logic                mem_rvalid,
  input  logic [31:0]         mem_rdata,
  output logic                xfer_req,
  output logic [31:0]         xfer_addr,
  output logic [15:0]         xfer_len,
  output logic [4:0]          xfer_ofs,
  output logic                xfer_sop,
  output logic                xfer_eop,
  input  logic                xfer_done,
  input  logic [15:0]         xfer_count,
  output logic                desc_done,
  output logic [IDX_W-1:0]    cur_idx
);

  localparam logic [ADDR_W-1:0] ADR_WORD_OFS = ADDR_W'(DESC_BYTES / 2);

  walk_state_e       st_q, st_d;
  logic [WORD_W-1:0] ctl_q, ctl_d;
  logic [WORD_W-1:0] adr_q, adr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              done_q, done_d;

  logic              tick, adv;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] desc_addr;

  logic                f_own, f_sop, f_eop;
  logic [CNT_W-1:0]    f_len;
  logic [TX_OFS_W-1:0] f_ofs;
  logic [WORD_W-1:0]   f_wb;
  logic                rd_own;

  dwalk_poll_timer #(.POLL_CYC(POLL_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ch_rst),
    .en    (cfg_poll_en),
    .div4  (cfg_poll_div4),
    .tick  (tick)
  );

  dwalk_ring_idx #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ch_rst),
    .adv   (adv),
    .len   (cfg_len),
    .idx   (idx)
  );

  dwalk_ctl_fmt u_fmt (
    .ctl     (ctl_q),
    .is_tx   (cfg_is_tx),
    .moved   (cnt_q),
    .own     (f_own),
    .sop     (f_sop),
    .eop     (f_eop),
    .len     (f_len),
    .ofs     (f_ofs),
    .wb_word (f_wb)
  );

  assign desc_addr = cfg_base + (ADDR_W'(idx) << DESC_SHIFT);
  assign rd_own    = mem_rdata[OWN_B];

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    ctl_d  = ctl_q;
    adr_d  = adr_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    adv    = 1'b0;

    unique case (st_q)
      W_IDLE: if (tick) st_d = W_RCTL;
      W_RCTL: if (mem_gnt) st_d = W_WCTL;
      W_WCTL: if (mem_rvalid) begin
        ctl_d = mem_rdata;
        st_d  = rd_own ? W_RADR : W_IDLE;
      end
      W_RADR: if (mem_gnt) st_d = W_WADR;
      W_WADR: if (mem_rvalid) begin
        adr_d = mem_rdata;
        st_d  = W_XFER;
      end
      W_XFER: if (xfer_done) begin
        cnt_d = xfer_count;
        st_d  = W_WB;
      end
      W_WB: if (mem_gnt) begin
        done_d = 1'b1;
        adv    = 1'b1;
        st_d   = W_RCTL;
      end
      default: st_d = W_IDLE;
    endcase

    if (ch_rst) begin
      st_d   = W_IDLE;
      done_d = 1'b0;
      adv    = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= W_IDLE;
      ctl_q  <= '0;
      adr_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      adr_q  <= adr_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // Outputs
  always_comb begin
    mem_req   = (st_q == W_RCTL) || (st_q == W_RADR) || (st_q == W_WB);
    mem_we    = (st_q == W_WB);
    mem_addr  = (st_q == W_RADR) ? desc_addr + ADR_WORD_OFS : desc_addr;
    mem_wdata = (st_q == W_WB) ? f_wb : '0;
    xfer_req  = (st_q == W_XFER);
    xfer_addr = adr_q;
    xfer_len  = f_len;
    xfer_ofs  = f_ofs;
    xfer_sop  = f_sop;
    xfer_eop  = f_eop;
  end

  assign desc_done = done_q;
  assign cur_idx   = idx;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || ch_rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))
      || ch_rst);  // R12

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n || ch_rst)
    (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))
      || ch_rst);  // R12

  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));  // R12

  AST_WB_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (!mem_wdata[OWN_B] && mem_wdata[CMPL_B]));  // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);  // R8

  AST_NEXT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> (mem_req && !mem_we));  // R9

  AST_UNOWNED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == W_WCTL && mem_rvalid && !rd_own && !ch_rst) |=> (!mem_req && !xfer_req));  // R5

  AST_CHRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ch_rst |=> (!mem_req && !xfer_req && !desc_done));  // R11

endmodule

// File: tb/tb_dring_walker.sv
module tb_dring_walker;

  localparam int unsigned POLL = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n, ch_rst;
  logic [31:0] cfg_base;
  logic [7:0]  cfg_len;
  logic        cfg_is_tx, cfg_poll_en, cfg_poll_div4;
  logic        mem_req, mem_we, mem_gnt, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        xfer_req, xfer_sop, xfer_eop, xfer_done;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len, xfer_count;
  logic [4:0]  xfer_ofs;
  logic        desc_done;
  logic [7:0]  cur_idx;

  always #4 clk = ~clk;

  dring_walker #(.ADDR_W(32), .IDX_W(8), .POLL_CYC(POLL)) dut (
    .clk(clk), .rst_n(rst_n), .ch_rst(ch_rst),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_is_tx(cfg_is_tx),
    .cfg_poll_en(cfg_poll_en), .cfg_poll_div4(cfg_poll_div4),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_ofs(xfer_ofs),
    .xfer_sop(xfer_sop), .xfer_eop(xfer_eop), .xfer_done(xfer_done),
    .xfer_count(xfer_count), .desc_done(desc_done), .cur_idx(cur_idx)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic [4:0]  ofs;
    logic        sop;
    logic        eop;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem [0:127];
  logic [31:0] orig_ctl [0:15];
  int          errors = 0, checks = 0;
  int          cyc = 0, done_cnt = 0, n_req = 0, n_wr = 0, n_ctl_rd = 0;
  int          last_rd = 0, prev_rd = 0, rd_lat = 1, rd_cnt = 0, rd_ix = 0;
  int          mv_cnt = 0, mv_short = 0, hold_bad = 0;
  exp_t        mv_cur;

  function automatic int widx(input logic [31:0] a);
    return int'((a - BASE) >> 2) & 127;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: grants immediately, answers reads after rd_lat cycles
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (rd_cnt != 0) begin
      rd_cnt = rd_cnt - 1;
      if (rd_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem[rd_ix];
      end
    end
    if (mem_req && mem_gnt) begin
      n_req++;
      if (mem_we) begin
        mem[widx(mem_addr)] = mem_wdata;
        n_wr++;
      end else begin
        rd_ix  = widx(mem_addr);
        rd_cnt = rd_lat;
        if (mem_addr[2] == 1'b0) begin
          prev_rd = last_rd;
          last_rd = cyc;
          n_ctl_rd++;
        end
      end
    end
    if (desc_done) done_cnt++;
  end

  // Data mover stub and scoreboard monitor (R6, R7, R12)
  always @(negedge clk) begin
    if (xfer_done) begin
      xfer_done = 1'b0;
    end else if (mv_cnt != 0) begin
      if (xfer_addr != mv_cur.addr || xfer_len != mv_cur.len) hold_bad++;
      mv_cnt = mv_cnt - 1;
      if (mv_cnt == 0) begin
        xfer_done  = 1'b1;
        xfer_count = mv_cur.len - 16'(mv_short);
      end
    end else if (xfer_req) begin
      mv_cur = '{addr: xfer_addr, len: xfer_len, ofs: xfer_ofs, sop: xfer_sop, eop: xfer_eop};
      if (sb_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected transfer", xfer_addr, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(mv_cur.addr == e.addr, "R6", "transfer address", mv_cur.addr, e.addr);
        chk({mv_cur.len, mv_cur.sop, mv_cur.eop} == {e.len, e.sop, e.eop},
            "R6", "length/sop/eop", {14'h0, mv_cur.len, mv_cur.sop, mv_cur.eop},
            {14'h0, e.len, e.sop, e.eop});
        chk(mv_cur.ofs == e.ofs, "R7", "byte offset", 32'(mv_cur.ofs), 32'(e.ofs));
      end
      mv_cnt = 3;
    end
  end

  // Driver: arms a descriptor (owner bit 31 set) and queues the expected transfer
  task automatic arm(input int i, input bit sop, input bit eop, input logic [4:0] ofsf,
                     input logic [15:0] len, input logic [31:0] a, input logic [4:0] exp_ofs);
    logic [31:0] c;
    c = {1'b1, 1'b0, sop, eop, ofsf, 7'h2B, len};
    orig_ctl[i]   = c;
    mem[2*i + 1]  = a;
    mem[2*i]      = c;
    sb_q.push_back('{addr: a, len: len, ofs: exp_ofs, sop: sop, eop: eop});
  endtask

  task automatic check_wb(input int i, input logic [15:0] moved);
    logic [31:0] e;
    e = orig_ctl[i];
    e[31] = 1'b0; e[30] = 1'b1; e[15:0] = moved;
    chk(mem[2*i] == e, "R8", $sformatf("write-back of entry %0d", i), mem[2*i], e);
  endtask

  task automatic wait_done(input int n);
    int t = 0;
    while (done_cnt < n && t < 4000) begin @(negedge clk); t++; end
    chk(done_cnt >= n, "R8", "completion count", 32'(done_cnt), 32'(n));
  endtask

  task automatic wait_ctl_rd();
    int start = n_ctl_rd;
    int t = 0;
    while (n_ctl_rd == start && t < 1000) begin @(negedge clk); t++; end
  endtask

  task automatic run_all();
    rst_n = 1'b0; ch_rst = 1'b0; cfg_base = BASE; cfg_len = 8'd4;
    cfg_is_tx = 1'b1; cfg_poll_en = 1'b0; cfg_poll_div4 = 1'b0;
    mem_gnt = 1'b1; mem_rvalid = 1'b0; mem_rdata = '0;
    xfer_done = 1'b0; xfer_count = '0;
    for (int k = 0; k < 128; k++) mem[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!mem_req && !xfer_req && !desc_done, "R1", "idle outputs after reset",
        {29'h0, mem_req, xfer_req, desc_done}, 32'h0);
    chk(cur_idx == 0, "R1", "index after reset", 32'(cur_idx), 32'h0);

    arm(0, 1'b1, 1'b0, 5'h13, 16'd100, 32'hA000_0000, 5'h13);
    arm(1, 1'b0, 1'b0, 5'h00, 16'd64,  32'hA000_0400, 5'h00);
    arm(2, 1'b0, 1'b1, 5'h1F, 16'd1,   32'hA000_0800, 5'h1F);

    // R2: polling disabled, owned entries untouched
    repeat (200) @(negedge clk);
    chk(n_req == 0, "R2", "memory requests with polling off", 32'(n_req), 32'h0);

    // R4, R5, R6, R9: walk three owned entries, stop at unowned entry 3
    cfg_poll_en = 1'b1;
    wait_done(3);
    repeat (40) @(negedge clk);
    chk(cur_idx == 3, "R9", "index after three completions", 32'(cur_idx), 32'd3);
    chk(sb_q.size() == 0, "R4", "all queued transfers seen", 32'(sb_q.size()), 32'h0);
    check_wb(0, 16'd100);
    check_wb(1, 16'd64);
    check_wb(2, 16'd1);

    // R5: unowned entry produces no write and no transfer over several ticks
    repeat (100) @(negedge clk);
    chk(n_wr == 3 && done_cnt == 3, "R5", "writes while entry unowned", 32'(n_wr), 32'd3);

    // R10: re-arm entry 3 and entry 0, walk wraps through 3 -> 0 -> stops at 1
    arm(0, 1'b0, 1'b1, 5'h07, 16'd12, 32'hB000_0000, 5'h07);
    arm(3, 1'b1, 1'b1, 5'h0A, 16'd300, 32'hA000_0C00, 5'h0A);
    // order of expectations: entry 3 first, then entry 0
    begin
      exp_t a, b;
      a = sb_q.pop_front(); b = sb_q.pop_front();
      sb_q.push_back(b); sb_q.push_back(a);
    end
    wait_done(5);
    repeat (30) @(negedge clk);
    chk(cur_idx == 1, "R10", "index after wrap", 32'(cur_idx), 32'd1);
    check_wb(3, 16'd300);
    check_wb(0, 16'd12);

    // R7, R8: receive channel, 3-bit offset, short transfer count
    cfg_is_tx = 1'b0; mv_short = 7;
    arm(1, 1'b1, 1'b0, 5'h1D, 16'd50, 32'hC000_0000, 5'h05);
    wait_done(6);
    repeat (20) @(negedge clk);
    check_wb(1, 16'd43);
    chk(cur_idx == 2, "R9", "index after receive entry", 32'(cur_idx), 32'd2);

    // R11: channel reset during a slow control-word fetch of entry 2
    cfg_is_tx = 1'b1; mv_short = 0; rd_lat = 10;
    wait_ctl_rd();
    repeat (12) @(negedge clk);
    orig_ctl[2] = {1'b1, 1'b0, 1'b0, 1'b0, 5'h01, 7'h2B, 16'd77};
    mem[5] = 32'hDEAD_0000; mem[4] = orig_ctl[2];
    arm(0, 1'b1, 1'b1, 5'h02, 16'd9, 32'hD000_0000, 5'h02);
    wait_ctl_rd();
    repeat (2) @(negedge clk);
    ch_rst = 1'b1;
    @(negedge clk);
    ch_rst = 1'b0;
    chk(cur_idx == 0, "R11", "index after channel reset", 32'(cur_idx), 32'h0);
    repeat (12) @(negedge clk);
    chk(!xfer_req && done_cnt == 6, "R11", "no transfer from aborted fetch",
        32'(done_cnt), 32'd6);
    wait_done(7);
    repeat (20) @(negedge clk);
    chk(mem[4] == orig_ctl[2], "R11", "aborted entry left unwritten", mem[4], orig_ctl[2]);
    check_wb(0, 16'd9);
    chk(sb_q.size() == 0, "R11", "scoreboard drained", 32'(sb_q.size()), 32'h0);

    // R3: poll spacing on unowned entry 1, plain and divided
    rd_lat = 1;
    wait_ctl_rd(); wait_ctl_rd();
    chk(last_rd - prev_rd == POLL, "R3", "poll spacing", 32'(last_rd - prev_rd), 32'(POLL));
    cfg_poll_div4 = 1'b1;
    wait_ctl_rd(); wait_ctl_rd(); wait_ctl_rd();
    chk(last_rd - prev_rd == 4 * POLL, "R3", "divided poll spacing",
        32'(last_rd - prev_rd), 32'(4 * POLL));

    chk(hold_bad == 0, "R12", "transfer fields held until done", 32'(hold_bad), 32'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 32'(cyc), 32'h0);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule